// File: doc/BRIEF.md
# Row-Column Switch Matrix Scanner

This block scans a matrix of diode-isolated switches arranged as 8 rows by 6 columns. It drives a 3-bit row select, which an external decoder turns into one active-low row line. After the row has had time to settle, the block pulses an active-low load strobe. That strobe copies the six column lines into an external 8-bit parallel-in, serial-out shift register. The two upper bits of that register are held high. The block then issues eight shift strobes and collects the serial bits one per strobe. A low bit means that the switch at the crossing of the active row and that bit's column is closed.

Rows are visited in ascending order and the sequence wraps after the last row. The decoded columns of each row are collected in a pending image. At the end of every full pass the whole 48-bit switch image is replaced in a single cycle, and a one-cycle done strobe marks the update. A programmable settle count sets how long each row select is held before the load strobe.

Top module: `swm_scanner`

## Requirements
- R1: While reset is held and in the first cycle after it, `row_sel` is 0, `sr_load_n` is 1, `sr_shift` is 0, `sw_state` is all zeros and `scan_done` is 0.
- R2: After `row_sel` takes a new value (or reset ends), it stays unchanged for `settle_cycles`+1 cycles, and `sr_load_n` is then low for exactly one cycle. The row select does not change while the load strobe is low.
- R3: The load strobe is followed, starting in the next cycle, by exactly 8 consecutive cycles with `sr_shift` high. `sr_shift` is never high while `sr_load_n` is low.
- R4: `ser_in` is sampled in each cycle in which `sr_shift` is high. The register delivers its most significant bit first: the first two samples are the padding bits, and the following six are columns 5 down to 0. A low sample means closed.
- R5: The two padding samples have no effect on the image. If they read low, the image is the same as if they read high.
- R6: Bit `row*6+col` of `sw_state` holds the switch at that row and column, with 1 meaning closed.
- R7: Each row lasts `settle_cycles`+11 cycles (settle, load, 8 shifts, one store cycle). The rows are visited 0,1,...,7 and then wrap to 0. `row_sel` changes only at the end of a row's store cycle.
- R8: `sw_state` changes only in the cycle in which `scan_done` is high. `scan_done` is a single-cycle pulse that follows the store cycle of row 7, and the new image holds every row's value as sampled during that pass.
- R9: The interval between consecutive `scan_done` pulses is 8×(`settle_cycles`+11) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | 8 | Extra cycles the row select is held before loading |
| row_sel | output | 3 | Index of the row currently driven low |
| sr_load_n | output | 1 | Active-low parallel-load strobe to the shift register |
| sr_shift | output | 1 | Shift strobe to the shift register, one bit per cycle |
| ser_in | input | 1 | Serial output of the shift register (its MSB) |
| sw_state | output | 48 | Switch image, 1 = closed, bit row*6+col |
| scan_done | output | 1 | One-cycle pulse when a new image is committed |

## Verification
The assertions assume that `settle_cycles` changes only at a pass boundary. They also assume that the external register loads on the clock edge that ends the low load strobe and shifts left on each edge that ends a shift strobe, so `ser_in` always shows the register's current top bit. The bench models that register in exactly this way. It changes the settle count and the switch pattern only just after a `scan_done` pulse, with one deliberate exception: in one pass the pattern is changed halfway through, to show that the image is committed per pass and that each row holds the value sampled when that row was scanned.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_LOAD   = 2'd1,
    PH_SHIFT  = 2'd2,
    PH_STORE  = 2'd3
  } phase_t;

  // Offset of a row's slice inside the flattened switch image.
  function automatic int slot_base(input int row, input int cols);
    return row * cols;
  endfunction

  // Cycles spent on one row for a given settle count.
  function automatic int row_period(input int settle, input int sr_bits);
    return settle + 1 + 1 + sr_bits + 1;
  endfunction
endpackage

// File: rtl/swm_phase_fsm.sv
module swm_phase_fsm #(
  parameter int SR_BITS  = 8,
  parameter int SETTLE_W = 8,
  localparam int BIT_W   = $clog2(SR_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                load_n,
  output logic                shift_en,
  output logic                row_done
);
  import swm_pkg::*;

  phase_t              phase;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [BIT_W-1:0]    bit_cnt;
  logic                settle_hit;
  logic                bit_last;

  assign settle_hit = (settle_cnt == settle_cycles);
  assign bit_last   = (bit_cnt == BIT_W'(SR_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_SETTLE;
      settle_cnt <= '0;
      bit_cnt    <= '0;
    end else begin
      case (phase)
        PH_SETTLE: begin
          if (settle_hit) phase <= PH_LOAD;
          else            settle_cnt <= settle_cnt + 1'b1;
        end
        PH_LOAD: begin
          phase   <= PH_SHIFT;
          bit_cnt <= '0;
        end
        PH_SHIFT: begin
          if (bit_last) phase <= PH_STORE;
          else          bit_cnt <= bit_cnt + 1'b1;
        end
        default: begin
          phase      <= PH_SETTLE;
          settle_cnt <= '0;
        end
      endcase
    end
  end

  assign load_n   = (phase != PH_LOAD);
  assign shift_en = (phase == PH_SHIFT);
  assign row_done = (phase == PH_STORE);
endmodule

// File: rtl/swm_row_ctr.sv
module swm_row_ctr #(
  parameter int NUM_ROWS = 8,
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_done,
  output logic [ROW_W-1:0] row_sel,
  output logic             last_row
);
  assign last_row = (row_sel == ROW_W'(NUM_ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        row_sel <= '0;
    else if (row_done) row_sel <= last_row ? '0 : row_sel + 1'b1;
  end
endmodule

// File: rtl/swm_capture.sv
module swm_capture #(
  parameter int NUM_COLS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                ser_in,
  output logic [NUM_COLS-1:0] col_bits
);
  // Only the last NUM_COLS samples stay in the register; the leading
  // padding samples fall off its top end.
  always_ff @(posedge clk) begin
    if (!rst_n)        col_bits <= '1;
    else if (shift_en) col_bits <= {col_bits[NUM_COLS-2:0], ser_in};
  end
endmodule

// File: rtl/swm_image.sv
module swm_image #(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 6,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int IMG_W   = NUM_ROWS * NUM_COLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_done,
  input  logic                last_row,
  input  logic [ROW_W-1:0]    row_sel,
  input  logic [NUM_COLS-1:0] col_bits,
  output logic [IMG_W-1:0]    sw_state,
  output logic                scan_done
);
  function automatic logic [NUM_COLS-1:0] closed_of(input logic [NUM_COLS-1:0] raw);
    return ~raw;
  endfunction

  logic [IMG_W-1:0] pend;
  logic [IMG_W-1:0] next_img;
  logic             commit;

  assign commit = row_done && last_row;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_slot
    localparam int BASE = swm_pkg::slot_base(r, NUM_COLS);
    assign next_img[BASE +: NUM_COLS] =
      (row_done && (row_sel == ROW_W'(r))) ? closed_of(col_bits)
                                           : pend[BASE +: NUM_COLS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      sw_state  <= '0;
      scan_done <= 1'b0;
    end else begin
      pend      <= next_img;
      scan_done <= commit;
      if (commit) sw_state <= next_img;
    end
  end
endmodule

// File: rtl/swm_scanner.sv
module swm_scanner #(
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 6,
  parameter int SR_BITS   = 8,
  parameter int SETTLE_W  = 8,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int IMG_W    = NUM_ROWS * NUM_COLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [ROW_W-1:0]    row_sel,
  output logic                sr_load_n,
  output logic                sr_shift,
  input  logic                ser_in,
  output logic [IMG_W-1:0]    sw_state,
  output logic                scan_done
);
  // Internal events, named for the checker.
  logic                load_evt;
  logic                shift_evt;
  logic                row_done;
  logic                last_row;
  logic                pass_end;
  logic [NUM_COLS-1:0] col_bits;

  swm_phase_fsm #(.SR_BITS(SR_BITS), .SETTLE_W(SETTLE_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .settle_cycles (settle_cycles),
    .load_n        (sr_load_n),
    .shift_en      (sr_shift),
    .row_done      (row_done)
  );

  swm_row_ctr #(.NUM_ROWS(NUM_ROWS)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_done (row_done),
    .row_sel  (row_sel),
    .last_row (last_row)
  );

  swm_capture #(.NUM_COLS(NUM_COLS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sr_shift),
    .ser_in   (ser_in),
    .col_bits (col_bits)
  );

  swm_image #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_img (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_done  (row_done),
    .last_row  (last_row),
    .row_sel   (row_sel),
    .col_bits  (col_bits),
    .sw_state  (sw_state),
    .scan_done (scan_done)
  );

  assign load_evt  = !sr_load_n;
  assign shift_evt = sr_shift;
  assign pass_end  = row_done && last_row;
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int NUM_ROWS = 8,
  parameter int SR_BITS  = 8,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int IMG_W   = NUM_ROWS * 6,
  localparam int CNT_W   = $clog2(SR_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] row_sel,
  input logic             load_evt,
  input logic             shift_evt,
  input logic             row_done,
  input logic             pass_end,
  input logic             scan_done,
  input logic [IMG_W-1:0] sw_state
);
  logic [CNT_W-1:0] shifts_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)         shifts_seen <= '0;
    else if (load_evt)  shifts_seen <= '0;
    else if (shift_evt) shifts_seen <= shifts_seen + 1'b1;
  end

  p_load_row_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> $stable(row_sel));
  p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);
  p_shift_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> shift_evt);
  p_no_shift_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && shift_evt));
  p_shift_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> (shifts_seen == CNT_W'(SR_BITS)));
  p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !row_done |=> $stable(row_sel));
  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_done && (row_sel != ROW_W'(NUM_ROWS - 1))) |=> (row_sel == ROW_W'($past(row_sel) + 1'b1)));
  p_row_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> (row_sel == '0));
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> scan_done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
  p_image_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> $stable(sw_state));
endmodule

bind swm_scanner swm_checker #(.NUM_ROWS(NUM_ROWS), .SR_BITS(SR_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .row_sel   (row_sel),
  .load_evt  (load_evt),
  .shift_evt (shift_evt),
  .row_done  (row_done),
  .pass_end  (pass_end),
  .scan_done (scan_done),
  .sw_state  (sw_state)
);

// File: tb/sim_swm_scanner.sv
`timescale 1ns/1ps
module sim_swm_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  settle = 8'd3;
  logic [2:0]  row_sel;
  logic        sr_load_n, sr_shift, ser_in;
  logic [47:0] sw_state;
  logic        scan_done;

  logic [47:0] closed = 48'h0;
  logic        pad_low = 1'b0;
  logic [7:0]  sr = 8'hFF;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  swm_scanner u0 (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle), .row_sel(row_sel),
    .sr_load_n(sr_load_n), .sr_shift(sr_shift), .ser_in(ser_in),
    .sw_state(sw_state), .scan_done(scan_done)
  );

  // External matrix and shift register model: a closed switch pulls its column low.
  function automatic logic [7:0] column_byte(input logic [2:0] r);
    logic [7:0] b;
    b[7:6] = pad_low ? 2'b00 : 2'b11;
    for (int c = 0; c < 6; c++) b[c] = ~closed[r*6 + c];
    return b;
  endfunction

  always @(posedge clk) begin
    if (!sr_load_n)    sr <= column_byte(row_sel);
    else if (sr_shift) sr <= {sr[6:0], 1'b1};
  end
  assign ser_in = sr[7];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle monitor for sequencing, timing and image stability.
  int          since_row = 1, since_load = 0, shifts = 0, pass_cyc = 0;
  logic [2:0]  prev_row = 0, last_load_row = 0;
  bit          have_load = 0, have_done = 0, prev_done = 0;
  logic [47:0] prev_state = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      since_row = 1; since_load = 0; shifts = 0; pass_cyc = 0;
      prev_row = 0; have_load = 0; have_done = 0; prev_done = 0; prev_state = 0;
    end else begin
      if (row_sel != prev_row) since_row = 1; else since_row++;
      prev_row = row_sel;
      since_load++;
      pass_cyc++;
      if (!sr_load_n) begin
        chk(since_row == int'(settle) + 2, "R2 settle before load", since_row, int'(settle) + 2);
        chk(!sr_shift, "R3 no shift during load", sr_shift, 0);
        if (have_load) begin
          chk(shifts == 8, "R3 shift count", shifts, 8);
          chk(row_sel == 3'(last_load_row + 3'd1), "R7 row order", row_sel, 3'(last_load_row + 3'd1));
        end
        have_load = 1; last_load_row = row_sel; shifts = 0; since_load = 0;
      end
      if (sr_shift) begin
        chk(since_load == shifts + 1, "R3 consecutive shifts", since_load, shifts + 1);
        chk(sr_load_n, "R3 load high while shifting", sr_load_n, 1);
        shifts++;
      end
      if (scan_done) begin
        chk(!prev_done, "R8 single-cycle done", prev_done, 0);
        chk(last_load_row == 3'd7, "R7 pass ends on last row", last_load_row, 7);
        if (have_done)
          chk(pass_cyc == 8 * (int'(settle) + 11), "R9 pass period", pass_cyc, 8 * (int'(settle) + 11));
        have_done = 1; pass_cyc = 0;
      end else begin
        chk(sw_state == prev_state, "R8 image held between passes", sw_state, prev_state);
      end
      prev_done = scan_done;
      prev_state = sw_state;
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!scan_done) @(negedge clk);
  endtask

  task automatic run_pass(input logic [47:0] pat, input logic [7:0] sv, input bit pl, input string req);
    #1;
    closed = pat; settle = sv; pad_low = pl;
    wait_done();
    chk(sw_state == pat, req, sw_state, pat);
  endtask

  initial begin
    logic [47:0] a, b, lo;
    closed = 48'h8000_0000_0001;
    repeat (3) @(negedge clk);
    chk(row_sel == 0 && sr_load_n && !sr_shift, "R1 reset controls", {row_sel, sr_load_n, sr_shift}, 5'b00010);
    chk(sw_state == 0 && !scan_done, "R1 reset image", {sw_state, scan_done}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(row_sel == 0 && sr_load_n && !sr_shift && sw_state == 0 && !scan_done,
        "R1 first cycle after reset", {sw_state, row_sel, sr_load_n, sr_shift, scan_done}, 6'b000100);
    wait_done();
    chk(sw_state == 48'h8000_0000_0001, "R6 corner switches", sw_state, 48'h8000_0000_0001);

    // R4 R6: walking closed switch at every row/column position.
    for (int i = 0; i < 48; i++) run_pass(48'h1 << i, 8'd0, 1'b0, "R6 walking closed");
    // R4: walking open switch with all others closed.
    for (int i = 0; i < 48; i++) run_pass(~(48'h1 << i), 8'd1, 1'b0, "R4 walking open");
    run_pass(48'h0, 8'd2, 1'b0, "R4 all open");
    run_pass(48'hFFFF_FFFF_FFFF, 8'd2, 1'b0, "R4 all closed");
    run_pass(48'hAAAA_AAAA_AAAA, 8'd4, 1'b0, "R6 checkerboard A");
    run_pass(48'h5555_5555_5555, 8'd4, 1'b0, "R6 checkerboard B");
    for (int r = 0; r < 8; r++) run_pass(48'h3F << (r * 6), 8'd0, 1'b0, "R6 full row");
    // R5: padding samples forced low must not alter the image.
    run_pass(48'h0, 8'd5, 1'b1, "R5 padding low, all open");
    run_pass(48'h1234_5678_9ABC, 8'd5, 1'b1, "R5 padding low, mixed");
    run_pass(48'hFFFF_0000_FFFF, 8'd20, 1'b0, "R9 long settle");

    // R8: pattern changed mid-pass; rows 0-3 keep the old value, rows 4-7 the new.
    a = 48'h0F0F_0F0F_0F0F; b = 48'hF0F0_F0F0_F0F0; lo = 48'h0000_00FF_FFFF;
    #1 closed = a; settle = 8'd2; pad_low = 1'b0;
    @(negedge clk);
    while (row_sel != 3'd4) @(negedge clk);
    #1 closed = b;
    wait_done();
    chk(sw_state == ((a & lo) | (b & ~lo)), "R8 per-row sampling in pass",
        sw_state, (a & lo) | (b & ~lo));
    run_pass(b, 8'd2, 1'b0, "R8 next pass settles");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule